// File: doc/BRIEF.md
# Tri-State Phase-Frequency Detector with Lock Indicator

This block compares two event streams inside one fast clock domain: a comparison strobe derived from the reference divider and a strobe derived from the divided oscillator feedback. Each input is a single-cycle pulse. Whichever strobe arrives first opens a correction request: an up request when the reference leads, a down request when the feedback leads. The request stays asserted until the other strobe arrives, so its width in clock cycles equals the phase error. Both requests are active low and rest high when the two streams are aligned.

The detector has three states: idle, up pending and down pending. A second strobe from the side that already leads is absorbed. The response is therefore linear across a full cycle of error in either direction, and a cycle slip folds back into the same pattern instead of building up an unbounded count.

A lock indicator watches the width of every correction pulse. Each comparison that closes with a pulse no longer than a programmable threshold counts as good. A run of consecutive good comparisons, four by default, raises the indicator. The first cycle in which a pulse grows past the threshold clears it, even if that pulse has not ended yet.

Top module: `pfd_lock_top`

## Requirements
- R1: While rst_n is low, up_n and dn_n are held high and lock is held low, whatever the strobe inputs do.
- R2: From idle, a reference strobe without a feedback strobe drives up_n low from the next cycle while dn_n stays high.
- R3: From idle, a feedback strobe without a reference strobe drives dn_n low from the next cycle while up_n stays high.
- R4: If the opposing strobe arrives k cycles after the opening strobe, the open request is low for exactly k cycles and returns high in the cycle after the closing strobe. Strobes that coincide in the same cycle produce no pulse on either output.
- R5: up_n and dn_n are never low in the same cycle.
- R6: A strobe from the side whose request is already open has no effect, so the pulse still ends one cycle after the opposing strobe (2π wraparound).
- R7: A comparison is good when it closes with a pulse of at most lock_thresh cycles; coincident strobes count as width 0. lock rises in the cycle after the LOCK_CYCLES-th consecutive good comparison (default 4), and never without a good comparison in the cycle before.
- R8: In any cycle where an open request has been low for more than lock_thresh cycles, including the current cycle, lock goes low in the next cycle and the good-comparison run restarts from zero. This applies even if the pulse has not closed yet.
- R9: Once raised, lock stays high through idle cycles, pulses within the threshold and further good comparisons.
- R10: With lock_thresh equal to 0, only coincident strobes are good: any visible request pulse clears lock in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common fast clock for strobes and state |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_stb | input | 1 | Single-cycle reference comparison strobe |
| fb_stb | input | 1 | Single-cycle divided-feedback strobe |
| lock_thresh | input | WIDTH_W (8) | Largest pulse width in cycles still accepted as locked |
| up_n | output | 1 | Active-low request to raise the oscillator frequency |
| dn_n | output | 1 | Active-low request to lower the oscillator frequency |
| lock | output | 1 | High after a run of good comparisons |

## Verification
A pending flag that is stuck or fails to clear shows up within one cycle as a request that outlives its closing strobe, or as both requests low together. Both show directly at up_n and dn_n. A pulse-width counter that runs one cycle off moves the cycle in which lock falls on a long pulse, so a pulse exactly at the threshold, and one cycle past it, tell the two cases apart. A faulty run counter appears as lock rising one comparison early or late. Periodic strobe pairs with small jitter, mixed with random bursts and threshold changes, reach all of these cases many times.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // lane 0 carries the reference side, lane 1 the feedback side
  localparam int LANE_REF = 0;
  localparam int LANE_FB  = 1;
  localparam int N_LANES  = 2;

  typedef logic [N_LANES-1:0] lane_vec_t;

  typedef enum logic [1:0] {
    PFD_IDLE    = 2'b00,
    PFD_UP_OPEN = 2'b01,
    PFD_DN_OPEN = 2'b10
  } pfd_mode_e;

  // a comparison closes when both sides are pending or arriving
  function automatic logic pfd_closes(lane_vec_t pend, lane_vec_t hit);
    lane_vec_t seen;
    seen = pend | hit;
    return &seen;
  endfunction

  // next pending vector of one lane given the close decision
  function automatic logic pfd_lane_next(logic pend, logic hit, logic close);
    logic nxt;
    if (close) nxt = 1'b0;
    else       nxt = pend | hit;
    return nxt;
  endfunction

  function automatic pfd_mode_e pfd_mode(lane_vec_t pend);
    pfd_mode_e m;
    case (pend)
      2'b01:   m = PFD_UP_OPEN;
      2'b10:   m = PFD_DN_OPEN;
      default: m = PFD_IDLE;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ref_stb,
  input  logic      fb_stb,
  output lane_vec_t pend_q,
  output logic      close_evt,
  output logic      active
);

  lane_vec_t hit;
  lane_vec_t pend_d;

  assign hit[LANE_REF] = ref_stb;
  assign hit[LANE_FB]  = fb_stb;

  assign close_evt = pfd_closes(pend_q, hit);

  // one pending flop per side; a second strobe on an open side is absorbed
  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    assign pend_d[g] = pfd_lane_next(pend_q[g], hit[g], close_evt);

    always_ff @(posedge clk) begin
      if (!rst_n) pend_q[g] <= 1'b0;
      else        pend_q[g] <= pend_d[g];
    end
  end

  assign active = (pfd_mode(pend_q) != PFD_IDLE);

endmodule

// File: rtl/pfd_width_meter.sv
module pfd_width_meter #(
  parameter int WIDTH_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               close_evt,
  input  logic [WIDTH_W-1:0] thresh,
  output logic               good_evt,
  output logic               bad_evt
);

  localparam logic [WIDTH_W-1:0] RUN_MAX = {WIDTH_W{1'b1}};

  // run_q counts earlier cycles of the open pulse; the current cycle adds one
  logic [WIDTH_W-1:0] run_q;
  logic [WIDTH_W-1:0] run_d;
  logic               overrun;

  function automatic logic [WIDTH_W-1:0] sat_step(logic [WIDTH_W-1:0] v);
    logic [WIDTH_W-1:0] r;
    if (v == RUN_MAX) r = v;
    else              r = v + 1'b1;
    return r;
  endfunction

  // pulse length so far is run_q + 1, too long when it exceeds thresh
  function automatic logic too_long(logic [WIDTH_W-1:0] run, logic [WIDTH_W-1:0] lim);
    return run >= lim;
  endfunction

  assign overrun  = active && too_long(run_q, thresh);
  assign bad_evt  = overrun;
  assign good_evt = close_evt && !overrun;

  assign run_d = active ? sat_step(run_q) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

endmodule

// File: rtl/pfd_lock_filter.sv
module pfd_lock_filter #(
  parameter int LOCK_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic good_evt,
  input  logic bad_evt,
  output logic lock_q
);

  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] TARGET = CNT_W'(LOCK_CYCLES);

  logic [CNT_W-1:0] streak_q;
  logic [CNT_W-1:0] streak_inc;

  function automatic logic [CNT_W-1:0] bump(logic [CNT_W-1:0] v);
    logic [CNT_W-1:0] r;
    if (v >= TARGET) r = TARGET;
    else             r = v + 1'b1;
    return r;
  endfunction

  assign streak_inc = bump(streak_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      streak_q <= '0;
      lock_q   <= 1'b0;
    end else if (bad_evt) begin
      streak_q <= '0;
      lock_q   <= 1'b0;
    end else if (good_evt) begin
      streak_q <= streak_inc;
      lock_q   <= (streak_inc >= TARGET);
    end
  end

endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
  import pfd_pkg::*;
#(
  parameter int WIDTH_W     = 8,
  parameter int LOCK_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_stb,
  input  logic               fb_stb,
  input  logic [WIDTH_W-1:0] lock_thresh,
  output logic               up_n,
  output logic               dn_n,
  output logic               lock
);

  lane_vec_t pend_q;
  logic      close_evt;
  logic      active;
  logic      good_evt;
  logic      bad_evt;

  pfd_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_stb   (ref_stb),
    .fb_stb    (fb_stb),
    .pend_q    (pend_q),
    .close_evt (close_evt),
    .active    (active)
  );

  pfd_width_meter #(.WIDTH_W(WIDTH_W)) u_meter (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .close_evt (close_evt),
    .thresh    (lock_thresh),
    .good_evt  (good_evt),
    .bad_evt   (bad_evt)
  );

  pfd_lock_filter #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .good_evt (good_evt),
    .bad_evt  (bad_evt),
    .lock_q   (lock)
  );

  assign up_n = ~pend_q[LANE_REF];
  assign dn_n = ~pend_q[LANE_FB];

endmodule

// File: rtl/pfd_lock_checker.sv
module pfd_lock_checker #(
  parameter int WIDTH_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ref_stb,
  input logic               fb_stb,
  input logic [WIDTH_W-1:0] lock_thresh,
  input logic               up_n,
  input logic               dn_n,
  input logic               lock,
  input logic               close_evt,
  input logic               good_evt,
  input logic               bad_evt
);

  AST_UP_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_stb && !fb_stb && up_n && dn_n) |=> (!up_n && dn_n)); // R2

  AST_DN_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_stb && !ref_stb && up_n && dn_n) |=> (!dn_n && up_n)); // R3

  AST_CLOSE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    close_evt |=> (up_n && dn_n)); // R4

  AST_UP_ENDS_ON_FB: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_n && fb_stb) |=> up_n); // R4

  AST_NO_DUAL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(!up_n && !dn_n)); // R5

  AST_REF_ABSORBED: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_n && ref_stb && !fb_stb) |=> (!up_n && dn_n)); // R6

  AST_LOCK_NEEDS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(good_evt)); // R7

  AST_LONG_PULSE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    bad_evt |=> !lock); // R8

  AST_ZERO_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
    ((!up_n || !dn_n) && lock_thresh == '0) |=> !lock); // R10

endmodule

bind pfd_lock_top pfd_lock_checker #(.WIDTH_W(WIDTH_W)) u_pfd_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ref_stb     (ref_stb),
  .fb_stb      (fb_stb),
  .lock_thresh (lock_thresh),
  .up_n        (up_n),
  .dn_n        (dn_n),
  .lock        (lock),
  .close_evt   (close_evt),
  .good_evt    (good_evt),
  .bad_evt     (bad_evt)
);

// File: tb/test_pfd_lock_top.sv
module test_pfd_lock_top;

  localparam int W     = 8;
  localparam int LOCKN = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         ref_stb;
  logic         fb_stb;
  logic [W-1:0] lock_thresh;
  logic         up_n;
  logic         dn_n;
  logic         lock;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // bench model: which side leads (0 none, 1 ref, 2 fb), cycles shown, run of goods
  int m_lead;
  int m_shown;
  int m_streak;
  bit m_lock;

  always #2 clk = ~clk;

  pfd_lock_top #(.WIDTH_W(W), .LOCK_CYCLES(LOCKN)) i_pfd_lock_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_stb     (ref_stb),
    .fb_stb      (fb_stb),
    .lock_thresh (lock_thresh),
    .up_n        (up_n),
    .dn_n        (dn_n),
    .lock        (lock)
  );

  function automatic bit ends_here(int lead, bit r, bit f);
    return (lead == 1 && f) || (lead == 2 && r) || (lead == 0 && r && f);
  endfunction

  function automatic bit too_wide(int lead, int shown, int th);
    return (lead != 0) && (shown > th);
  endfunction

  task automatic model_edge(bit r, bit f);
    bit c;
    bit o;
    c = ends_here(m_lead, r, f);
    o = too_wide(m_lead, m_shown, int'(lock_thresh));
    if (o) begin
      m_streak = 0;
      m_lock   = 0;
    end else if (c) begin
      if (m_streak < LOCKN) m_streak++;
      if (m_streak >= LOCKN) m_lock = 1;
    end
    if (c) begin
      m_lead = 0; m_shown = 0;
    end else if (m_lead == 0 && r) begin
      m_lead = 1; m_shown = 1;
    end else if (m_lead == 0 && f) begin
      m_lead = 2; m_shown = 1;
    end else if (m_lead != 0) begin
      m_shown++;
    end
  endtask

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit r, bit f, string tp, string tl);
    model_edge(r, f);
    ref_stb = r;
    fb_stb  = f;
    @(posedge clk);
    #1;
    check(tp, "up_n", int'(up_n), int'(m_lead != 1));
    check(tp, "dn_n", int'(dn_n), int'(m_lead != 2));
    check(tl, "lock", int'(lock), int'(m_lock));
    check("R5", "both low", int'(!up_n && !dn_n), 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    int w;
    void'($urandom(32'd5150));
    rst_n = 1'b0; ref_stb = 1'b1; fb_stb = 1'b0; lock_thresh = W'(3);
    repeat (3) @(posedge clk);
    #1;
    check("R1", "up_n in reset", int'(up_n), 1);
    check("R1", "dn_n in reset", int'(dn_n), 1);
    check("R1", "lock in reset", int'(lock), 0);
    ref_stb = 1'b0;
    rst_n = 1'b1;
    m_lead = 0; m_shown = 0; m_streak = 0; m_lock = 0;
    @(posedge clk);
    #1;
    check("R1", "up_n after reset", int'(up_n), 1);

    // R2 / R4: reference leads by 3 cycles
    w = 0;
    for (int i = 0; i < 3; i++) begin
      step(i == 0, 1'b0, "R2", "R7");
      w += int'(!up_n);
    end
    step(1'b0, 1'b1, "R4", "R7");
    check("R4", "up width for lead of 3", w, 3);

    // R3 / R4: feedback leads by 2 cycles
    w = 0;
    for (int i = 0; i < 2; i++) begin
      step(i == 0 ? 1'b0 : 1'b0, i == 0, "R3", "R7");
      w += int'(!dn_n);
    end
    step(1'b1, 1'b0, "R4", "R7");
    check("R4", "dn width for lead of 2", w, 2);

    // R4: coincident strobes, third good comparison
    step(1'b1, 1'b1, "R4", "R7");
    check("R4", "no pulse on coincidence", int'(up_n && dn_n), 1);
    check("R7", "not locked after three goods", int'(lock), 0);

    // R6: extra reference strobe while up is open, close with both strobes
    w = 0;
    step(1'b1, 1'b0, "R6", "R7"); w += int'(!up_n);
    step(1'b1, 1'b0, "R6", "R7"); w += int'(!up_n);
    step(1'b0, 1'b0, "R6", "R7"); w += int'(!up_n);
    step(1'b1, 1'b1, "R6", "R7");
    check("R6", "width unchanged by repeat ref", w, 3);
    check("R7", "locked after fourth good", int'(lock), 1);

    // R8: pulse of 4 cycles against threshold 3, lock drops before it closes
    step(1'b1, 1'b0, "R2", "R9");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R2", "R9");
    check("R9", "lock held at width equal to threshold", int'(lock), 1);
    step(1'b0, 1'b0, "R8", "R8");
    check("R8", "lock dropped on overlong pulse", int'(lock), 0);
    step(1'b0, 1'b1, "R8", "R8");

    // R7 / R9: relock with small jitter and hold
    for (int k = 0; k < 10; k++) begin
      step(1'b1, 1'b0, "R7", "R7");
      step(1'b0, 1'b1, "R7", "R7");
      step(1'b0, 1'b0, "R9", "R9");
      if (k == 2) check("R7", "no lock after three goods", int'(lock), 0);
      if (k == 3) check("R7", "lock after four goods", int'(lock), 1);
    end
    check("R9", "lock held through further goods", int'(lock), 1);

    // R10: zero threshold, a one-cycle pulse clears lock
    lock_thresh = '0;
    step(1'b1, 1'b1, "R10", "R10");
    check("R10", "coincidence keeps lock", int'(lock), 1);
    step(1'b0, 1'b1, "R10", "R10");
    step(1'b1, 1'b0, "R10", "R10");
    check("R10", "one-cycle pulse clears lock", int'(lock), 0);

    // random phase: jittered periodic pairs mixed with random bursts
    for (int blk = 0; blk < 500; blk++) begin
      int mode;
      int off;
      mode = int'($urandom % 4);
      off  = int'($urandom % 6);
      if ($urandom % 8 == 0) lock_thresh = W'($urandom % 6);
      for (int s = 0; s < 10; s++) begin
        bit r;
        bit f;
        if (mode == 3) begin
          r = ($urandom % 4 == 0);
          f = ($urandom % 4 == 0);
        end else begin
          r = (s == 2);
          f = (s == off);
        end
        step(r, f, "R6", "R9");
      end
    end

    done = 1;
    finish_run();
  end

endmodule